// File: doc/BRIEF.md
# Carry-Save Montgomery Modular Multiplier

This block computes the Montgomery product A·B·2^(-K) mod N for a K-bit odd modulus N using a bit-serial radix-2 loop. The operands come in as plain binary words and the product goes out as a plain binary word. Inside the block the running sum is held as a pair of vectors, sum and carry, so that no carry ever ripples across the word while the loop runs.

A single adder level does all of the arithmetic, and each of its cells has two modes. In the first mode each cell is a full adder, which the main loop uses for its three-input carry-save accumulation. In the second mode each cell is a chain of half adders in series. The block uses this mode before the loop to form B+N, and again after the loop to collapse the sum/carry pair into binary. The HA_STEPS parameter sets how many half-adder stages are chained in one cycle, and a value of 2 roughly halves the cycles these two phases take.

A loop iteration whose addend is zero, and whose vectors are both even, bypasses the adder altogether. A caller pulses `start` with the operands on the inputs, then waits for the one-cycle `done` pulse. The result is below 2N, and no final subtraction is applied to it.

Top module: `mont_csa_mul`

## Requirements
- R1: When `done` is high, `result` modulo N equals A·B·2^(-K) mod N for the A, B and N sampled with `start`, provided that N is odd and A, B < N.
- R2: When `done` is high, `result` (K+1 bits, unsigned binary) is strictly less than 2N. No subtraction of N is applied.
- R3: `done` is high for exactly one clock cycle per accepted operation.
- R4: Operands are captured on the rising edge where `start` is high while the block is idle. A `start` pulse that arrives during an operation is ignored, and the pending result stays that of the first operation.
- R5: The main loop runs exactly K iterations, one per bit of A starting from the least significant bit. With A = B = 0, `done` is first seen high right after the (K+4)-th rising edge, counting the edge that samples `start` as the first.
- R6: B+N is formed before the loop, and the final sum/carry pair is made binary after the loop, in the half-adder mode of the shared adder level. Each such cycle performs HA_STEPS half-adder stages, and either phase ends as soon as the carry vector is zero. The total latency never exceeds K + 4 + 2·ceil((K+2)/HA_STEPS) edges, counted as in R5.
- R7: An iteration whose addend (0, B, N or B+N) is zero and whose sum and carry vectors are both even skips the adder and only halves both vectors. Such an iteration still uses one cycle and still advances the bit index.
- R8: After reset, `done` is low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; honoured only when idle |
| a_in | input | K | Multiplier operand A, binary |
| b_in | input | K | Multiplicand operand B, binary |
| n_in | input | K | Odd modulus N, binary |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | K+1 | Montgomery product, binary, below 2N |

## Verification
The bench builds the block with K = 32 and HA_STEPS = 2. With K = 32, moduli that use the full word are in play, including N = 2^32−1, for which B+N and the loop sum both reach bit K. That exercises the extra top bit of the vectors and the longest half-adder carry chains. With HA_STEPS = 2, the measured latencies check the halved pre- and post-loop phases against the R6 bound. The A = B = 0 case drives every loop iteration through the bypass path, and its exact latency checks that no iteration is dropped.

// File: rtl/mont_pkg.sv
// Shared types for the carry-save Montgomery multiplier.
package mont_pkg;
    // Sequencer phases: idle, B+N precompute, main loop, binary conversion.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_LOOP = 2'd2,
        PH_POST = 2'd3
    } mont_phase_e;
endpackage

// File: rtl/mont_csa_cell_row.sv
// One configurable adder level across W bits.
// Full-adder mode: s = x^y^z, c = majority(x,y,z). The carry is NOT shifted
// left, because the caller treats it as already divided by two.
// Half-adder mode: z is ignored, and HA_STEPS half-adder stages run in series,
// each producing s = x^y and c = (x&y)<<1. x+y is kept intact as long as
// x+y < 2^W.
module mont_csa_cell_row #(
    parameter int W        = 33,
    parameter int HA_STEPS = 2
) (
    input  logic         fa_mode,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    logic [W-1:0] hs [HA_STEPS+1];
    logic [W-1:0] hc [HA_STEPS+1];

    assign hs[0] = x;
    assign hc[0] = y;

    // Chain of half-adder stages, one per generate step.
    for (genvar g = 0; g < HA_STEPS; g++) begin : g_ha
        assign hs[g+1] = hs[g] ^ hc[g];
        assign hc[g+1] = (hs[g] & hc[g]) << 1;
    end

    // Mode select between the full-adder view and the half-adder chain.
    always_comb begin
        if (fa_mode) begin
            s = x ^ y ^ z;
            c = (x & y) | (x & z) | (y & z);
        end else begin
            s = hs[HA_STEPS];
            c = hc[HA_STEPS];
        end
    end
endmodule

// File: rtl/mont_addend_sel.sv
// Picks the addend of one Montgomery iteration. The inputs are the current
// bit of A and the low bits of the sum and carry vectors.
// The parity bit q makes sum+carry+addend even.
// Selection: {a,q} = 00 -> 0, 10 -> B, 01 -> N, 11 -> B+N.
module mont_addend_sel #(
    parameter int W = 33
) (
    input  logic         a_bit,
    input  logic         s_lsb,
    input  logic         c_lsb,
    input  logic [W-1:0] b_val,
    input  logic [W-1:0] n_val,
    input  logic [W-1:0] bn_val,
    output logic [W-1:0] addend
);
    logic q_bit;

    // Parity and four-way operand mux.
    always_comb begin
        q_bit = s_lsb ^ c_lsb ^ (a_bit & b_val[0]);
        unique case ({a_bit, q_bit})
            2'b00:   addend = '0;
            2'b10:   addend = b_val;
            2'b01:   addend = n_val;
            default: addend = bn_val;
        endcase
    end
endmodule

// File: rtl/mont_csa_mul.sv
// Radix-2 Montgomery multiplier with carry-save accumulation.
// Assumes N is odd and A, B < N, and the sequence below depends on it.
// A start pulse in idle latches the operands. In the PRE phase the adder row
// (half-adder mode) forms B+N. The LOOP phase runs K iterations in
// full-adder mode. In the POST phase the row (half-adder mode) collapses
// sum/carry to binary, and done pulses once with result < 2N.
module mont_csa_mul #(
    parameter int K        = 32,
    parameter int HA_STEPS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [K-1:0] a_in,
    input  logic [K-1:0] b_in,
    input  logic [K-1:0] n_in,
    output logic         done,
    output logic [K:0]   result
);
    import mont_pkg::*;

    localparam int W    = K + 1;
    localparam int IDXW = (K > 1) ? $clog2(K) : 1;
    localparam int CNTW = $clog2(K + 1) + 1;

    mont_phase_e   phase;
    logic [K-1:0]  a_sh;
    logic [W-1:0]  b_q, n_q, bn_q, s_q, c_q;
    logic [IDXW-1:0] idx;

    logic [W-1:0]  addend, row_s, row_c;
    logic          fa_mode, skip;

    mont_addend_sel #(.W(W)) u_sel (
        .a_bit  (a_sh[0]),
        .s_lsb  (s_q[0]),
        .c_lsb  (c_q[0]),
        .b_val  (b_q),
        .n_val  (n_q),
        .bn_val (bn_q),
        .addend (addend)
    );

    mont_csa_cell_row #(.W(W), .HA_STEPS(HA_STEPS)) u_row (
        .fa_mode (fa_mode),
        .x       (s_q),
        .y       (c_q),
        .z       (addend),
        .s       (row_s),
        .c       (row_c)
    );

    // Row mode and the zero-addend bypass decision.
    always_comb begin
        fa_mode = (phase == PH_LOOP);
        skip    = (phase == PH_LOOP) && (addend == '0) && !s_q[0] && !c_q[0];
    end

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            a_sh   <= '0;
            b_q    <= '0;
            n_q    <= '0;
            bn_q   <= '0;
            s_q    <= '0;
            c_q    <= '0;
            idx    <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        a_sh  <= a_in;
                        b_q   <= {1'b0, b_in};
                        n_q   <= {1'b0, n_in};
                        s_q   <= {1'b0, b_in};
                        c_q   <= {1'b0, n_in};
                        phase <= PH_PRE;
                    end
                end
                PH_PRE: begin
                    if (c_q == '0) begin
                        bn_q  <= s_q;
                        s_q   <= '0;
                        c_q   <= '0;
                        idx   <= '0;
                        phase <= PH_LOOP;
                    end else begin
                        s_q <= row_s;
                        c_q <= row_c;
                    end
                end
                PH_LOOP: begin
                    if (skip) begin
                        s_q <= s_q >> 1;
                        c_q <= c_q >> 1;
                    end else begin
                        s_q <= row_s >> 1;
                        c_q <= row_c;
                    end
                    a_sh <= a_sh >> 1;
                    idx  <= idx + 1'b1;
                    if (idx == IDXW'(K - 1)) phase <= PH_POST;
                end
                default: begin
                    if (c_q == '0) begin
                        result <= s_q;
                        done   <= 1'b1;
                        phase  <= PH_IDLE;
                    end else begin
                        s_q <= row_s;
                        c_q <= row_c;
                    end
                end
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [W+1:0] cs_total, step_total;
    logic [CNTW-1:0] loop_cnt;

    // Widened sums used to check value conservation across cycles.
    always_comb begin
        cs_total   = (W+2)'(s_q) + (W+2)'(c_q);
        step_total = cs_total + (W+2)'(addend);
    end

    // Counts loop cycles of the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n || phase == PH_IDLE) loop_cnt <= '0;
        else if (phase == PH_LOOP)      loop_cnt <= loop_cnt + 1'b1;
    end

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((K+2)'(result) < ((K+2)'(n_q) << 1)));

    p_operands_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> ($stable(b_q) && $stable(n_q)));

    p_pre_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PRE && c_q == '0) |-> (s_q == b_q + n_q));

    p_loop_halves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOOP) |=> ({cs_total[W:0], 1'b0} == $past(step_total)));

    p_loop_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_POST) |-> (loop_cnt == CNTW'(K)));
endmodule

// File: tb/mont_csa_mul_bench.sv
module mont_csa_mul_bench;
    localparam int K   = 32;
    localparam int HS  = 2;
    localparam int LAT_MAX = K + 4 + 2 * ((K + 2 + HS - 1) / HS);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [K-1:0] a_in = '0, b_in = '0, n_in = '0;
    logic         done;
    logic [K:0]   result;

    int checks = 0;
    int fails  = 0;
    logic [63:0] exp_q[$];
    logic [63:0] mod_q[$];
    logic prev_done = 1'b0;
    logic [31:0] rng = 32'h1234_5679;

    always #4 clk = ~clk;

    mont_csa_mul #(.K(K), .HA_STEPS(HS)) u_mont_csa_mul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_in(a_in), .b_in(b_in), .n_in(n_in),
        .done(done), .result(result)
    );

    // Plain-integer radix-2 Montgomery reference, reduced mod N.
    function automatic logic [63:0] ref_mont(logic [63:0] a, logic [63:0] b, logic [63:0] n);
        logic [63:0] u = 0;
        for (int i = 0; i < K; i++) begin
            if (a[i]) u = u + b;
            if (u[0]) u = u + n;
            u = u >> 1;
        end
        return u % n;
    endfunction

    function automatic logic [31:0] next_rng(logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each done pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) check(1'b0, "R3 done width", 2, 1);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected result", 1, 0);
                end else begin
                    logic [63:0] e, n;
                    e = exp_q.pop_front();
                    n = mod_q.pop_front();
                    check((64'(result) % n) == e, "R1 residue", 64'(result) % n, e);
                    check(64'(result) < 2 * n, "R2 below 2N", 64'(result), 2 * n);
                end
            end
            prev_done = done;
        end
    end

    // Driver: queue the expected value, pulse start, count edges to done.
    task automatic run_op(logic [K-1:0] a, logic [K-1:0] b, logic [K-1:0] n,
                          bit inject, output int lat);
        exp_q.push_back(ref_mont(64'(a), 64'(b), 64'(n)));
        mod_q.push_back(64'(n));
        a_in = a; b_in = b; n_in = n; start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (inject && lat == 3) begin
                a_in = ~a; b_in = n - 1; n_in = n; start = 1'b1;
            end
        end while (!done && lat < 4 * LAT_MAX);
        start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R8 done after reset", 64'(done), 0);
        check(result == '0, "R8 result after reset", 64'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 / R7: all-zero operands, every iteration takes the bypass.
        run_op('0, '0, 32'hF000_0001, 1'b0, lat);
        check(lat == K + 4, "R5 R7 exact latency", lat, K + 4);

        run_op(32'd1, 32'd1, 32'd3, 1'b0, lat);
        check(lat <= LAT_MAX, "R6 latency bound", lat, LAT_MAX);
        run_op(32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, lat);
        check(lat <= LAT_MAX, "R6 latency bound all-ones", lat, LAT_MAX);
        run_op(32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF - 32'd0, 1'b0, lat);
        run_op('0, '0, 32'd1, 1'b0, lat);
        run_op(32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0001, 1'b0, lat);
        check(lat <= LAT_MAX, "R6 latency bound top bit", lat, LAT_MAX);

        // R4: second start while busy must not disturb the first result.
        run_op(32'h1234_5678, 32'h0BAD_CAFE, 32'hC001_D00D, 1'b1, lat);
        repeat (LAT_MAX + 4) @(negedge clk);
        check(exp_q.size() == 0, "R4 no extra result", exp_q.size(), 0);

        for (int v = 0; v < 30; v++) begin
            logic [31:0] n, a, b;
            rng = next_rng(rng); n = rng | 32'h8000_0001;
            rng = next_rng(rng); a = rng % n;
            rng = next_rng(rng); b = rng % n;
            run_op(a, b, n, 1'b0, lat);
            check(lat <= LAT_MAX, "R6 latency bound random", lat, LAT_MAX);
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R1 all results seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule